// File: doc/BRIEF.md
# Bypassing Instruction Holding Buffer

This block is a small ordered holding buffer placed between two stages of an in-order, multi-threaded pipeline. Every stored entry is a tag of thread number and sequence number, plus a payload. When an instruction arrives at the stage in front of the buffer, the block decides in the same cycle whether it can skip the buffered stage and go directly to the stage two positions ahead. If it cannot, it must be written into the buffer in the next stage and taken out again in the stage after that.

The storage side accepts four kinds of request, each at most once per cycle: append at the tail, delete the first entry that matches a tag, drop the oldest entry, and a per-thread squash of every entry younger than a given sequence number. The oldest entry is always visible on the head outputs. Deletions from the middle close the gap in the same cycle. A running count of bypassed instructions is kept. The state of the downstream stage (blocked per thread, free input slots) arrives as plain inputs.

Top module: `ibuf_bypass_top`

## Requirements
- R1: `dec_bypass` is high in the same cycle exactly when `arr_valid` is high, `empty` is high, `ds_blocked[arr_tid]` is low and `ds_free` is nonzero.
- R2: `dec_buffer` is high exactly when `arr_valid` is high and `dec_bypass` is low. `dec_next_ofs` is 2 for a bypass, 1 for a buffered arrival and 0 when nothing arrives.
- R3: `byp_count` rises by one on the clock edge after each cycle with `dec_bypass` high, and holds its value otherwise.
- R4: An insert request is accepted (`ins_ok` high, same cycle) only when the occupancy at the start of the cycle is below DEPTH. Otherwise `ins_deny` is high and the request changes nothing.
- R5: Accepted inserts go to the tail, so entries leave in the order they arrived.
- R6: A remove request with tag (`rm_tid`, `rm_seq`) deletes only the oldest entry whose thread and sequence number both match, and raises `rm_hit`. With no match the contents stay unchanged and `rm_hit` stays low.
- R7: `head_*` shows the oldest entry without removing it, and `head_valid` shows whether any entry exists. `pop_valid` removes the oldest entry, and has no effect on an empty buffer.
- R8: A squash removes every entry whose thread equals `sq_tid` and whose sequence number is strictly greater than `sq_seq`, compared as unsigned 16-bit values. All other entries stay.
- R9: After deletions, the surviving entries occupy the lowest positions by the next cycle and keep their relative order.
- R10: Requests in one cycle apply in this order: squash, then remove-by-tag on the survivors, then pop on what remains, then the insert goes to the tail.
- R11: A synchronous active-high reset empties the buffer and clears `byp_count`. `occupancy`, `full` (occupancy equals DEPTH) and `empty` (occupancy zero) are registered and agree after every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 1 | An instruction arrives for a bypass decision |
| arr_tid | input | 2 | Thread of the arriving instruction |
| ds_blocked | input | 4 | Per-thread blocked flags of the stage two ahead |
| ds_free | input | 2 | Free input slots of the stage two ahead |
| dec_bypass | output | 1 | Arrival skips the buffered stage |
| dec_buffer | output | 1 | Arrival must be inserted and later removed |
| dec_next_ofs | output | 2 | Stage distance to the arrival's next stage |
| byp_count | output | 16 | Bypassed instruction count |
| ins_valid | input | 1 | Insert request |
| ins_tid | input | 2 | Insert thread |
| ins_seq | input | 16 | Insert sequence number |
| ins_pay | input | 8 | Insert payload |
| ins_ok | output | 1 | Insert accepted |
| ins_deny | output | 1 | Insert refused, buffer full |
| rm_valid | input | 1 | Remove-by-tag request |
| rm_tid | input | 2 | Remove tag thread |
| rm_seq | input | 16 | Remove tag sequence number |
| rm_hit | output | 1 | Remove request found an entry |
| pop_valid | input | 1 | Remove the oldest entry |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | 2 | Squash thread |
| sq_seq | input | 16 | Squash sequence boundary |
| head_valid | output | 1 | Buffer holds at least one entry |
| head_tid | output | 2 | Oldest entry thread |
| head_seq | output | 16 | Oldest entry sequence number |
| head_pay | output | 8 | Oldest entry payload |
| occupancy | output | 3 | Stored entry count |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |

## Verification
The decision logic is swept over every arriving thread, every pattern of per-thread blocking and every free-slot value, once with the buffer empty and once with one entry held. This separates each of the three bypass conditions, and shows that blocking on another thread does not matter. The storage is tried with fills to capacity, with removes that hit the head, the middle, a duplicated tag or nothing, with squashes whose boundary equals a stored sequence number, and with every request kind in one cycle. Together these separate the priority order from each operation on its own. A long stream of mixed random requests over a narrow tag range then forces frequent matches, and each cycle it is compared against an ordered-list model on occupancy, flags and head.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
    parameter int TID_W = 2;
    parameter int SEQ_W = 16;
    parameter int PAY_W = 8;

    typedef struct packed {
        logic [TID_W-1:0] tid;
        logic [SEQ_W-1:0] seq;
        logic [PAY_W-1:0] pay;
    } entry_t;
endpackage

// File: rtl/ibuf_bypass_decide.sv
module ibuf_bypass_decide
    import ibuf_pkg::*;
#(
    parameter int FREE_W = 2,
    parameter int BCNT_W = 16,
    localparam int NTHR = 1 << TID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arr_valid,
    input  logic [TID_W-1:0]  arr_tid,
    input  logic              buf_empty,
    input  logic [NTHR-1:0]   ds_blocked,
    input  logic [FREE_W-1:0] ds_free,
    output logic              bypass,
    output logic              buffer,
    output logic [1:0]        next_ofs,
    output logic [BCNT_W-1:0] byp_cnt
);
    typedef struct packed {
        logic [BCNT_W-1:0] byp;
    } dstate_t;

    dstate_t st_d, st_q;

    always_comb begin
        bypass   = arr_valid && buf_empty && !ds_blocked[arr_tid] && (ds_free != '0);
        buffer   = arr_valid && !bypass;
        next_ofs = bypass ? 2'd2 : (arr_valid ? 2'd1 : 2'd0);
        st_d     = st_q;
        if (bypass) st_d.byp = st_q.byp + BCNT_W'(1);
        if (rst)    st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign byp_cnt = st_q.byp;

    // R3
    byp_step_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |=> byp_cnt == $past(byp_cnt) + BCNT_W'(1));
    // R3
    byp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bypass |=> $stable(byp_cnt));
    // R1
    byp_empty_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |-> buf_empty);
endmodule

// File: rtl/ibuf_compact.sv
module ibuf_compact
    import ibuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  entry_t [DEPTH-1:0] src,
    input  logic   [DEPTH-1:0] keep,
    output entry_t [DEPTH-1:0] dst,
    output logic   [CW-1:0]    n
);
    always_comb begin
        dst = '0;
        n   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                dst[n[IW-1:0]] = src[i];
                n = n + CW'(1);
            end
        end
    end
endmodule

// File: rtl/ibuf_store.sv
module ibuf_store
    import ibuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    input  entry_t           ins_entry,
    output logic             ins_ok,
    output logic             ins_deny,
    input  logic             rm_valid,
    input  logic [TID_W-1:0] rm_tid,
    input  logic [SEQ_W-1:0] rm_seq,
    output logic             rm_hit,
    input  logic             pop_valid,
    input  logic             sq_valid,
    input  logic [TID_W-1:0] sq_tid,
    input  logic [SEQ_W-1:0] sq_seq,
    output entry_t           head,
    output logic             head_valid,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic   [CW-1:0]    cnt;
        logic               full;
        logic               empty;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0] live, sq_kill, keep_sq, keep_rm, keep_fin;
    logic             rm_found, pop_found;
    entry_t [DEPTH-1:0] cmp_ent;
    logic   [CW-1:0]    cmp_n;

    // survivor masks: squash, then tag remove, then pop
    always_comb begin
        live      = '0;
        sq_kill   = '0;
        rm_found  = 1'b0;
        pop_found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            live[i]    = (i < int'(s_q.cnt));
            sq_kill[i] = sq_valid && live[i] && (s_q.ent[i].tid == sq_tid)
                         && (s_q.ent[i].seq > sq_seq);
        end
        keep_sq = live & ~sq_kill;
        keep_rm = keep_sq;
        for (int i = 0; i < DEPTH; i++) begin
            if (rm_valid && !rm_found && keep_sq[i] && (s_q.ent[i].tid == rm_tid)
                && (s_q.ent[i].seq == rm_seq)) begin
                keep_rm[i] = 1'b0;
                rm_found   = 1'b1;
            end
        end
        keep_fin = keep_rm;
        for (int i = 0; i < DEPTH; i++) begin
            if (pop_valid && !pop_found && keep_rm[i]) begin
                keep_fin[i] = 1'b0;
                pop_found   = 1'b1;
            end
        end
    end

    ibuf_compact #(.DEPTH(DEPTH)) u_compact (
        .src  (s_q.ent),
        .keep (keep_fin),
        .dst  (cmp_ent),
        .n    (cmp_n)
    );

    always_comb begin
        ins_ok   = ins_valid && !s_q.full;
        ins_deny = ins_valid && s_q.full;
        rm_hit   = rm_found;
        s_d      = s_q;
        s_d.ent  = cmp_ent;
        s_d.cnt  = cmp_n;
        if (ins_ok) begin
            s_d.ent[cmp_n[IW-1:0]] = ins_entry;
            s_d.cnt = cmp_n + CW'(1);
        end
        s_d.full  = (s_d.cnt == CW'(DEPTH));
        s_d.empty = (s_d.cnt == '0);
        if (rst) begin
            s_d       = '0;
            s_d.empty = 1'b1;
        end
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign head       = s_q.ent[0];
    assign head_valid = !s_q.empty;
    assign count      = s_q.cnt;
    assign full       = s_q.full;
    assign empty      = s_q.empty;

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R4
    deny_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && full && !sq_valid && !rm_valid && !pop_valid)
        |=> $stable(s_q.cnt) && (s_q.ent == $past(s_q.ent)));
    // R5
    ins_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_ok && !sq_valid && !rm_valid && !pop_valid)
        |=> count == $past(count) + CW'(1));
    // R7
    pop_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_valid && !empty && !sq_valid && !rm_valid && !ins_valid)
        |=> count == $past(count) - CW'(1));
    // R6
    rm_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (rm_valid && !rm_hit && !sq_valid && !pop_valid && !ins_valid)
        |=> $stable(count));
endmodule

// File: rtl/ibuf_bypass_top.sv
module ibuf_bypass_top
    import ibuf_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int FREE_W = 2,
    parameter int BCNT_W = 16,
    localparam int NTHR = 1 << TID_W,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arr_valid,
    input  logic [TID_W-1:0]  arr_tid,
    input  logic [NTHR-1:0]   ds_blocked,
    input  logic [FREE_W-1:0] ds_free,
    output logic              dec_bypass,
    output logic              dec_buffer,
    output logic [1:0]        dec_next_ofs,
    output logic [BCNT_W-1:0] byp_count,
    input  logic              ins_valid,
    input  logic [TID_W-1:0]  ins_tid,
    input  logic [SEQ_W-1:0]  ins_seq,
    input  logic [PAY_W-1:0]  ins_pay,
    output logic              ins_ok,
    output logic              ins_deny,
    input  logic              rm_valid,
    input  logic [TID_W-1:0]  rm_tid,
    input  logic [SEQ_W-1:0]  rm_seq,
    output logic              rm_hit,
    input  logic              pop_valid,
    input  logic              sq_valid,
    input  logic [TID_W-1:0]  sq_tid,
    input  logic [SEQ_W-1:0]  sq_seq,
    output logic              head_valid,
    output logic [TID_W-1:0]  head_tid,
    output logic [SEQ_W-1:0]  head_seq,
    output logic [PAY_W-1:0]  head_pay,
    output logic [CW-1:0]     occupancy,
    output logic              full,
    output logic              empty
);
    entry_t new_ent, head_ent;

    assign new_ent = '{tid: ins_tid, seq: ins_seq, pay: ins_pay};

    ibuf_bypass_decide #(.FREE_W(FREE_W), .BCNT_W(BCNT_W)) u_decide (
        .clk        (clk),
        .rst        (rst),
        .arr_valid  (arr_valid),
        .arr_tid    (arr_tid),
        .buf_empty  (empty),
        .ds_blocked (ds_blocked),
        .ds_free    (ds_free),
        .bypass     (dec_bypass),
        .buffer     (dec_buffer),
        .next_ofs   (dec_next_ofs),
        .byp_cnt    (byp_count)
    );

    ibuf_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .ins_valid  (ins_valid),
        .ins_entry  (new_ent),
        .ins_ok     (ins_ok),
        .ins_deny   (ins_deny),
        .rm_valid   (rm_valid),
        .rm_tid     (rm_tid),
        .rm_seq     (rm_seq),
        .rm_hit     (rm_hit),
        .pop_valid  (pop_valid),
        .sq_valid   (sq_valid),
        .sq_tid     (sq_tid),
        .sq_seq     (sq_seq),
        .head       (head_ent),
        .head_valid (head_valid),
        .count      (occupancy),
        .full       (full),
        .empty      (empty)
    );

    assign head_tid = head_ent.tid;
    assign head_seq = head_ent.seq;
    assign head_pay = head_ent.pay;
endmodule

// File: tb/ibuf_bypass_top_test.sv
`timescale 1ns/1ps
module ibuf_bypass_top_test;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arr_valid = 1'b0;
    logic [1:0]  arr_tid = '0;
    logic [3:0]  ds_blocked = '0;
    logic [1:0]  ds_free = '0;
    logic        dec_bypass, dec_buffer;
    logic [1:0]  dec_next_ofs;
    logic [15:0] byp_count;
    logic        ins_valid = 1'b0;
    logic [1:0]  ins_tid = '0;
    logic [15:0] ins_seq = '0;
    logic [7:0]  ins_pay = '0;
    logic        ins_ok, ins_deny;
    logic        rm_valid = 1'b0;
    logic [1:0]  rm_tid = '0;
    logic [15:0] rm_seq = '0;
    logic        rm_hit;
    logic        pop_valid = 1'b0;
    logic        sq_valid = 1'b0;
    logic [1:0]  sq_tid = '0;
    logic [15:0] sq_seq = '0;
    logic        head_valid;
    logic [1:0]  head_tid;
    logic [15:0] head_seq;
    logic [7:0]  head_pay;
    logic [2:0]  occupancy;
    logic        full, empty;

    int n_chk = 0;
    int n_err = 0;
    int m_n = 0;
    int m_byp = 0;
    int m_tid [DEPTH];
    int m_seq [DEPTH];
    int m_pay [DEPTH];

    always #10 clk = ~clk;

    ibuf_bypass_top uut (.*);

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_state(string tag);
        chk({tag, " occupancy"}, int'(occupancy), m_n);
        chk({tag, " empty R11"}, int'(empty), int'(m_n == 0));
        chk({tag, " full R11"}, int'(full), int'(m_n == DEPTH));
        chk({tag, " head_valid R7"}, int'(head_valid), int'(m_n > 0));
        chk({tag, " byp_count R3"}, int'(byp_count), m_byp);
        if (m_n > 0) begin
            chk({tag, " head_tid R7"}, int'(head_tid), m_tid[0]);
            chk({tag, " head_seq R7"}, int'(head_seq), m_seq[0]);
            chk({tag, " head_pay R7"}, int'(head_pay), m_pay[0]);
        end
    endtask

    // one cycle of storage requests, checked against an ordered-list model (R10 order)
    task automatic op(string tag, bit iv, int it, int is, int ip, bit rv, int rt, int rs,
                      bit pv, bit sv, int st, int ss);
        bit keep [DEPTH];
        bit hit, popd, ok;
        int k;
        int nt [DEPTH];
        int ns [DEPTH];
        int np [DEPTH];
        ins_valid = iv; ins_tid = 2'(it); ins_seq = 16'(is); ins_pay = 8'(ip);
        rm_valid = rv;  rm_tid = 2'(rt);  rm_seq = 16'(rs);
        pop_valid = pv;
        sq_valid = sv;  sq_tid = 2'(st);  sq_seq = 16'(ss);
        #1;
        for (int i = 0; i < DEPTH; i++) keep[i] = (i < m_n);
        if (sv) for (int i = 0; i < DEPTH; i++)
            if (keep[i] && m_tid[i] == st && m_seq[i] > ss) keep[i] = 0;
        hit = 0;
        if (rv) for (int i = 0; i < DEPTH; i++)
            if (!hit && keep[i] && m_tid[i] == rt && m_seq[i] == rs) begin
                keep[i] = 0; hit = 1;
            end
        popd = 0;
        if (pv) for (int i = 0; i < DEPTH; i++)
            if (!popd && keep[i]) begin keep[i] = 0; popd = 1; end
        ok = iv && (m_n < DEPTH);
        chk({tag, " ins_ok R4"}, int'(ins_ok), int'(ok));
        chk({tag, " ins_deny R4"}, int'(ins_deny), int'(iv && !ok));
        chk({tag, " rm_hit R6"}, int'(rm_hit), int'(hit));
        k = 0;
        for (int i = 0; i < DEPTH; i++) if (keep[i]) begin
            nt[k] = m_tid[i]; ns[k] = m_seq[i]; np[k] = m_pay[i]; k++;
        end
        if (ok) begin nt[k] = it; ns[k] = is; np[k] = ip; k++; end
        for (int i = 0; i < k; i++) begin
            m_tid[i] = nt[i]; m_seq[i] = ns[i]; m_pay[i] = np[i];
        end
        m_n = k;
        @(posedge clk);
        @(negedge clk);
        ins_valid = 0; rm_valid = 0; pop_valid = 0; sq_valid = 0;
        chk_state(tag);
    endtask

    task automatic ins(string tag, int t, int s, int p);
        op(tag, 1, t, s, p, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic drain(string tag);
        while (m_n > 0) op(tag, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic sweep(string tag);
        bit exp_b;
        for (int t = 0; t < 4; t++)
            for (int b = 0; b < 16; b++)
                for (int f = 0; f < 4; f++) begin
                    arr_valid = 1; arr_tid = 2'(t); ds_blocked = 4'(b); ds_free = 2'(f);
                    #1;
                    exp_b = (m_n == 0) && !b[t] && (f != 0);
                    chk({tag, " dec_bypass R1"}, int'(dec_bypass), int'(exp_b));
                    chk({tag, " dec_buffer R2"}, int'(dec_buffer), int'(!exp_b));
                    chk({tag, " dec_next_ofs R2"}, int'(dec_next_ofs), exp_b ? 2 : 1);
                    @(posedge clk);
                    @(negedge clk);
                    if (exp_b) m_byp++;
                    chk({tag, " byp_count R3"}, int'(byp_count), m_byp);
                end
        arr_valid = 0;
        #1;
        chk({tag, " idle bypass R1"}, int'(dec_bypass), 0);
        chk({tag, " idle ofs R2"}, int'(dec_next_ofs), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        chk_state("reset R11");

        // decision sweep, empty then holding one entry
        sweep("sweep empty");
        ins("R5 fill one", 1, 7, 3);
        sweep("sweep held");
        drain("R7 drain");

        // capacity and ordering
        ins("R4 fill", 0, 10, 1);
        ins("R4 fill", 1, 20, 2);
        ins("R4 fill", 0, 30, 3);
        ins("R4 fill", 2, 40, 4);
        ins("R4 overfill", 3, 50, 5);
        op("R7 peek", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        op("R7 peek", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        op("R6 R9 mid remove", 0, 0, 0, 0, 1, 0, 30, 0, 0, 0, 0);
        op("R6 miss", 0, 0, 0, 0, 1, 3, 99, 0, 0, 0, 0);
        drain("R5 order");
        op("R7 pop empty", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);

        // duplicated tag: only the oldest leaves
        ins("R6 dup", 1, 5, 7);
        ins("R6 dup", 1, 5, 9);
        op("R6 dup remove", 0, 0, 0, 0, 1, 1, 5, 0, 0, 0, 0);
        chk("R6 dup survivor payload", int'(head_pay), 9);
        drain("R6 drain");

        // squash with boundary equal to a stored number
        ins("R8 fill", 2, 100, 1);
        ins("R8 fill", 1, 200, 2);
        ins("R8 fill", 2, 101, 3);
        ins("R8 fill", 2, 99, 4);
        op("R8 squash", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 100);
        chk("R8 survivors", int'(occupancy), 3);
        drain("R8 R9 drain");

        // every request kind in one cycle
        ins("R10 fill", 0, 1, 1);
        ins("R10 fill", 1, 2, 2);
        ins("R10 fill", 0, 3, 3);
        op("R10 combo", 1, 3, 9, 8, 1, 1, 2, 1, 1, 0, 1);
        chk("R10 combo head seq", int'(head_seq), 9);
        drain("R10 drain");

        // mixed random stream over a narrow tag range
        for (int c = 0; c < 4000; c++)
            op("R10 random", bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
               int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
               $urandom_range(0, 3) == 0, int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
               $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
               int'($urandom_range(0, 3)), int'($urandom_range(0, 7)));
        drain("R5 final drain");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule